// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables from memory. A client hands it a virtual address and the kind of access it wants (read, write or instruction fetch). The walker reads one directory entry, then one table entry, through a memory read port that allows one read in flight. It checks presence and permissions, and returns either the physical address or a fault code.

Pages are 4 KB. The top ten address bits pick a directory slot and the next ten pick a slot in the second-level table that the directory entry names. The low twelve bits pass straight through as the offset in the frame. A root register holds the directory base. Software reloads it on a context switch, so the same virtual address can resolve to a different frame for each context. The walker copies the root register when it accepts a request, so a reload during a walk only affects later requests.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, done is 0, mem_rd_valid is 0, paddr is 0 and fault is 00.
- R2: Entry layout: bit 0 is present, bit 1 is writable, bit 2 is execute-disable, and bits 31..12 are a 4 KB-aligned base. The first read goes to {root[31:12],12'h000} + vaddr[31:22]*4. The second read goes to {dir_entry[31:12],12'h000} + vaddr[21:12]*4.
- R3: When both entries are present and the access is permitted, paddr = {table_entry[31:12], vaddr[11:0]} and fault = 00.
- R4: A directory entry with bit 0 clear gives fault 01 and paddr 0, and no second read is issued.
- R5: A table entry with bit 0 clear gives fault 10 and paddr 0.
- R6: Access codes are 00 read, 01 write, 10 execute, and 11, which is treated as read. A write faults unless bit 1 is set in both entries. An execute faults if bit 2 is set in either entry. A permission fault gives fault 11 and paddr 0. A read of a present page never faults on permissions.
- R7: done is high for exactly one cycle per request. paddr and fault change only in that cycle and hold their values until the next completion.
- R8: A request is taken only while req_ready is 1. req_ready drops on the cycle after a request is taken and stays low through the done cycle.
- R9: Only one memory read is outstanding. mem_rd_valid stays high with a stable mem_rd_addr until mem_rd_ready is seen. No new read is issued before the response (mem_rsp_valid) of the previous read.
- R10: root_wr loads root_data into the root register, and the low 12 bits of root_data are ignored. A walk uses the root value held when its request was taken. A load during a walk affects only later requests. After a reload, the same virtual address resolves through the new tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| root_wr | input | 1 | Load the root register |
| root_data | input | 32 | New directory base (bits 31..12 used) |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 32 | Physical address (0 on fault) |
| fault | output | 2 | 00 none, 01 directory absent, 10 table absent, 11 permission |

## Verification
The case that is hardest to reach from the ports is a root reload that lands while a walk is in flight. From the ports it is invisible unless the walk is slow enough for the reload to fall between acceptance and the directory read, and unless the two roots lead to different frames. The bench's memory model adds several cycles of stall before it accepts a read and several cycles of latency before it answers. This holds the walker in its fetch and wait states. The bench loads a second root during that window, and the second tree maps the same virtual page to another frame. The bench then expects the old frame for the walk already in progress and the new frame for the next request.

// File: rtl/ptw_pkg.sv
// Package: shared types for the two-level page table walker.
// Assumes: entries are 32 bits and the flag positions below are fixed.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH_DIR = 3'd1,
        ST_WAIT_DIR  = 3'd2,
        ST_FETCH_TBL = 3'd3,
        ST_WAIT_TBL  = 3'd4,
        ST_DONE      = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_TBL  = 2'd2,
        FLT_PERM = 2'd3
    } fault_e;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_NOEXEC  = 2;

endpackage

// File: rtl/ptw_index.sv
// Module: ptw_index
// Splits the virtual address into per-level indices and forms the byte
// address of the entry for the level being fetched.
// Assumes: table bases are aligned to 2**OFF_W bytes and entries are
// 2**ENT_LOG2 bytes. Level 0 is the directory and the last level is the table.
module ptw_index #(
    parameter int VA_W     = 32,
    parameter int IDX_W    = 10,
    parameter int OFF_W    = 12,
    parameter int ENT_LOG2 = 2,
    parameter int LEVELS   = 2
) (
    input  logic [VA_W-1:0]           vaddr,
    input  logic [VA_W-1:0]           table_base,
    input  logic [$clog2(LEVELS)-1:0] level,
    output logic [VA_W-1:0]           fetch_addr
);
    localparam int BASE_W = VA_W - OFF_W;

    logic [IDX_W-1:0] idx [LEVELS];

    // One index slice per level, taken from the top of the address downward.
    for (genvar l = 0; l < LEVELS; l++) begin : g_slice
        assign idx[l] = vaddr[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
    end

    // Entry address: aligned base plus the index scaled by the entry size.
    always_comb begin
        fetch_addr = {table_base[VA_W-1:OFF_W], {OFF_W{1'b0}}}
                   + (VA_W'(idx[level]) << ENT_LOG2);
    end

    logic unused_low;
    assign unused_low = ^{table_base[OFF_W-1:0], BASE_W[0]};

endmodule

// File: rtl/ptw_entry_check.sv
// Module: ptw_entry_check
// Decodes a returned entry and combines its permissions with those of the
// directory entry already fetched.
// Assumes: only meaningful for the table level. For the directory level the
// walker uses only the present flag.
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [ENT_W-1:0] dir_entry,
    input  access_e          access,
    output logic             present,
    output logic             perm_ok
);
    logic eff_write;
    logic eff_exec;

    // Combined rights: writable only if both levels allow it, executable
    // only if neither level forbids it.
    always_comb begin
        present   = entry[BIT_PRESENT];
        eff_write = entry[BIT_WRITE] & dir_entry[BIT_WRITE];
        eff_exec  = ~(entry[BIT_NOEXEC] | dir_entry[BIT_NOEXEC]);
        unique case (access)
            ACC_WRITE: perm_ok = eff_write;
            ACC_EXEC:  perm_ok = eff_exec;
            default:   perm_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/ptw_ctrl.sv
// Module: ptw_ctrl
// Walk sequencer: takes a request in idle, issues the directory read and then
// the table read, and ends in a one-cycle done state carrying the fault code.
// Assumes: the memory answers each accepted read with exactly one response.
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   mem_rd_ready,
    input  logic   mem_rsp_valid,
    input  logic   ent_present,
    input  logic   perm_ok,
    output logic   req_ready,
    output logic   accept,
    output logic   mem_rd_valid,
    output logic   level,
    output logic   dir_load,
    output logic   finish,
    output fault_e fin_fault,
    output logic   done
);
    walk_state_e state, state_nx;
    logic [1:0]  rd_cnt;

    // Outputs decoded from the current state.
    always_comb begin
        req_ready    = (state == ST_IDLE);
        accept       = req_ready && req_valid;
        mem_rd_valid = (state == ST_FETCH_DIR) || (state == ST_FETCH_TBL);
        level        = (state == ST_FETCH_TBL) || (state == ST_WAIT_TBL);
        done         = (state == ST_DONE);
        dir_load     = (state == ST_WAIT_DIR) && mem_rsp_valid;
    end

    // Next state, plus the finishing strobe and its fault code.
    always_comb begin
        state_nx  = state;
        finish    = 1'b0;
        fin_fault = FLT_NONE;
        unique case (state)
            ST_IDLE:      if (req_valid) state_nx = ST_FETCH_DIR;
            ST_FETCH_DIR: if (mem_rd_ready) state_nx = ST_WAIT_DIR;
            ST_WAIT_DIR: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        state_nx  = ST_DONE;
                        finish    = 1'b1;
                        fin_fault = FLT_DIR;
                    end else begin
                        state_nx = ST_FETCH_TBL;
                    end
                end
            end
            ST_FETCH_TBL: if (mem_rd_ready) state_nx = ST_WAIT_TBL;
            ST_WAIT_TBL: begin
                if (mem_rsp_valid) begin
                    state_nx = ST_DONE;
                    finish   = 1'b1;
                    if (!ent_present)  fin_fault = FLT_TBL;
                    else if (!perm_ok) fin_fault = FLT_PERM;
                    else               fin_fault = FLT_NONE;
                end
            end
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Reads issued in the current walk, used by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n || accept)                   rd_cnt <= 2'd0;
        else if (mem_rd_valid && mem_rd_ready)  rd_cnt <= rd_cnt + 2'd1;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4
    dir_fault_one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_cnt != 2'd1) |-> (rd_cnt == 2'd2));

endmodule

// File: rtl/pt_walker.sv
// Module: pt_walker (top)
// Two-level page table walker. It holds the root register, captures each
// request, and drives the index and permission logic with the sequencer.
// It also registers the result.
// Assumes: the memory returns entries in order, one read at a time, and the
// table contents do not change during a walk.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int IDX_W    = 10,
    parameter int OFF_W    = 12,
    parameter int ENT_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_access,
    input  logic            root_wr,
    input  logic [VA_W-1:0] root_data,
    output logic            mem_rd_valid,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_ready,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data,
    output logic            done,
    output logic [VA_W-1:0] paddr,
    output logic [1:0]      fault
);
    localparam int LEVELS = 2;
    localparam int BASE_W = VA_W - OFF_W;

    logic [BASE_W-1:0] root_q;
    logic [BASE_W-1:0] walk_root;
    logic [VA_W-1:0]   va_q;
    access_e           acc_q;
    logic [VA_W-1:0]   dir_q;
    logic [VA_W-1:0]   paddr_q;
    fault_e            fault_q;

    logic              accept;
    logic              level;
    logic              dir_load;
    logic              finish;
    fault_e            fin_fault;
    logic              ent_present;
    logic              perm_ok;
    logic [VA_W-1:0]   tbl_base;

    // Root register; software may load it at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)       root_q <= '0;
        else if (root_wr) root_q <= root_data[VA_W-1:OFF_W];
    end

    // Request capture: the address, the access kind and a copy of the root.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_root <= '0;
            va_q      <= '0;
            acc_q     <= ACC_READ;
        end else if (accept) begin
            walk_root <= root_q;
            va_q      <= req_vaddr;
            acc_q     <= access_e'(req_access);
        end
    end

    // Directory entry kept for the table fetch and the permission merge.
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_q <= '0;
        else if (dir_load) dir_q <= mem_rsp_data;
    end

    // Result register, written only when a walk ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else if (finish) begin
            fault_q <= fin_fault;
            paddr_q <= (fin_fault == FLT_NONE)
                     ? {mem_rsp_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
        end
    end

    // Table base for the current level.
    always_comb begin
        tbl_base = level ? dir_q : {walk_root, {OFF_W{1'b0}}};
    end

    ptw_index #(
        .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
        .ENT_LOG2(ENT_LOG2), .LEVELS(LEVELS)
    ) u_index (
        .vaddr      (va_q),
        .table_base (tbl_base),
        .level      (level),
        .fetch_addr (mem_rd_addr)
    );

    ptw_entry_check #(.ENT_W(VA_W)) u_check (
        .entry     (mem_rsp_data),
        .dir_entry (dir_q),
        .access    (acc_q),
        .present   (ent_present),
        .perm_ok   (perm_ok)
    );

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_present   (ent_present),
        .perm_ok       (perm_ok),
        .req_ready     (req_ready),
        .accept        (accept),
        .mem_rd_valid  (mem_rd_valid),
        .level         (level),
        .dir_load      (dir_load),
        .finish        (finish),
        .fin_fault     (fin_fault),
        .done          (done)
    );

    assign paddr = paddr_q;
    assign fault = fault_q;

    logic unused_root_low;
    assign unused_root_low = ^root_data[OFF_W-1:0];

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(paddr) && $stable(fault)));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> $stable(mem_rd_addr));

    // R10
    root_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(walk_root));

    // R6
    perm_fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'b00) |-> (paddr == '0));

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        root_wr = 1'b0;
    logic [31:0] root_data = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] paddr;
    logic [1:0]  fault;

    always #5 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access),
        .root_wr(root_wr), .root_data(root_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .done(done), .paddr(paddr), .fault(fault)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] root_now = '0;
    logic [31:0] addr_q [$];
    int stall = 0;
    int lat = 0;

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  f;
        string       tag;
    } exp_t;
    exp_t sb [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Reference walk from the requirements.
    function automatic void model(input logic [31:0] b, input logic [31:0] va,
                                  input logic [1:0] acc,
                                  output logic [31:0] pa, output logic [1:0] f);
        logic [31:0] d, t;
        pa = 32'h0;
        d = rd({b[31:12], 12'h000} + {20'h0, va[31:22], 2'b00});
        if (!d[0]) begin f = 2'b01; return; end
        t = rd({d[31:12], 12'h000} + {20'h0, va[21:12], 2'b00});
        if (!t[0]) begin f = 2'b10; return; end
        if ((acc == 2'b01 && !(d[1] && t[1])) || (acc == 2'b10 && (d[2] || t[2]))) begin
            f = 2'b11; return;
        end
        f = 2'b00;
        pa = {t[31:12], va[11:0]};
    endfunction

    // Driver: wait for idle, present one request, push the expected result.
    task automatic issue(input logic [31:0] va, input logic [1:0] acc, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        model(root_now, va, acc, e.pa, e.f);
        e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1;
        req_vaddr = va;
        req_access = acc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load_root(input logic [31:0] v);
        @(negedge clk);
        root_wr = 1'b1;
        root_data = v;
        @(negedge clk);
        root_wr = 1'b0;
        root_now = v;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Memory model: stall before accepting a read, answer after a latency.
    initial begin
        int phase = 0;
        int sn = 0;
        int ln = 0;
        logic [31:0] cap = '0;
        forever begin
            @(negedge clk);
            mem_rd_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (phase == 0 && mem_rd_valid) begin
                if (sn >= stall) begin
                    mem_rd_ready = 1'b1;
                    cap = mem_rd_addr;
                    addr_q.push_back(mem_rd_addr);
                    phase = 1; sn = 0; ln = 0;
                end else sn++;
            end else if (phase == 1) begin
                if (ln >= lat) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = rd(cap);
                    phase = 0;
                end else ln++;
            end
        end
    end

    // Monitor: compare each completion with the scoreboard.
    initial begin
        exp_t e;
        logic [31:0] last_pa;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                last_pa = paddr;
                if (sb.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", {31'h0, done}, 32'h0);
                end else begin
                    e = sb.pop_front();
                    chk(paddr == e.pa, {e.tag, " paddr"}, paddr, e.pa);
                    chk(fault == e.f, {e.tag, " fault"}, {30'h0, fault}, {30'h0, e.f});
                end
                chk(req_ready == 1'b0, "R8 ready low in done cycle", {31'h0, req_ready}, 32'h0);
                @(negedge clk);
                chk(done == 1'b0, "R7 done one cycle", {31'h0, done}, 32'h0);
                chk(paddr == last_pa, "R7 paddr held", paddr, last_pa);
                chk(req_ready == 1'b1, "R8 ready after done", {31'h0, req_ready}, 32'h1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=%h exp=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Root A tree.
        mem[32'h0001_000C] = 32'h0002_0003;
        mem[32'h0002_00C0] = 32'h0ABC_D003;
        mem[32'h0002_00C4] = 32'h0111_1001;
        mem[32'h0002_00C8] = 32'h0222_2007;
        mem[32'h0002_00CC] = 32'h0000_0000;
        mem[32'h0001_001C] = 32'h0003_0005;
        mem[32'h0003_0000] = 32'h0333_3003;
        mem[32'h0001_0FFC] = 32'h0004_0001;
        mem[32'h0004_0FFC] = 32'hFFFF_F001;
        // Root B tree.
        mem[32'h0005_000C] = 32'h0006_0003;
        mem[32'h0006_00C0] = 32'h0777_7003;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", {31'h0, req_ready}, 32'h1);
        chk(done == 1'b0, "R1 done", {31'h0, done}, 32'h0);
        chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);
        chk(paddr == 32'h0, "R1 paddr", paddr, 32'h0);
        chk(fault == 2'b00, "R1 fault", {30'h0, fault}, 32'h0);
        rst_n = 1'b1;

        load_root(32'h0001_0000);

        // R3 basic read translation
        issue(32'h00C3_0404, 2'b00, "R3 read");
        drain();
        // R2 fetch addresses at the top index boundary, offset all ones
        addr_q.delete();
        issue(32'hFFFF_FFFF, 2'b00, "R3 boundary");
        drain();
        chk(addr_q.size() == 2, "R2 read count", addr_q.size(), 2);
        if (addr_q.size() == 2) begin
            chk(addr_q[0] == 32'h0001_0FFC, "R2 dir addr", addr_q[0], 32'h0001_0FFC);
            chk(addr_q[1] == 32'h0004_0FFC, "R2 tbl addr", addr_q[1], 32'h0004_0FFC);
        end
        // R4 directory absent: one read only
        addr_q.delete();
        issue(32'h0140_0000, 2'b00, "R4 dir absent");
        drain();
        chk(addr_q.size() == 1, "R4 single read", addr_q.size(), 1);
        // R5 table absent
        issue(32'h00C3_3000, 2'b00, "R5 tbl absent");
        // R6 permission cases
        issue(32'h00C3_1000, 2'b01, "R6 write read-only table");
        issue(32'h00C3_1000, 2'b00, "R6 read read-only");
        issue(32'h00C3_1000, 2'b11, "R6 code 11 as read");
        issue(32'h00C3_2010, 2'b10, "R6 exec table no-exec");
        issue(32'h00C3_2010, 2'b01, "R6 write ok");
        issue(32'h01C0_0123, 2'b01, "R6 write dir read-only");
        issue(32'h01C0_0123, 2'b10, "R6 exec dir no-exec");
        issue(32'h01C0_0123, 2'b00, "R6 read through dir");
        issue(32'h00C3_0404, 2'b10, "R6 exec ok");
        drain();

        // R9/R8 with stalls and latency; R10 reload mid-walk
        stall = 5; lat = 3;
        issue(32'h00C3_0404, 2'b00, "R10 walk keeps old root");
        @(negedge clk);
        chk(req_ready == 1'b0, "R8 busy during walk", {31'h0, req_ready}, 32'h0);
        load_root(32'h0005_0ABC);
        drain();
        issue(32'h00C3_0404, 2'b00, "R10 new root frame");
        drain();
        stall = 1; lat = 0;
        load_root(32'h0001_0000);
        issue(32'h00C3_0404, 2'b00, "R10 back to first root");
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule